// File: doc/BRIEF.md
# Channel Trigger Router with Scan Expansion

This block decides, on every clock, which analog input channels ask the conversion arbiter for service. Each of the channels has a 4-bit source selector. The selector picks one of these sources for that channel: none, a one-shot software strobe, a held software level, a periodic tick from an internal counter, one of eleven external event lines, or the shared scan trigger. The scan trigger is different from the others. It does not start one channel. It starts every channel whose selector holds the scan code and whose bit in a membership mask is set. It has its own 4-bit selector, which uses the same encoding except that the scan code itself is reserved.

All configuration arrives as plain ports. The outputs are one-cycle request pulses, one bit per channel, and each pulse is registered one clock after the source event that caused it. The requests are plain control pulses with no back-pressure: the arbiter is expected to queue them. The arbiter reports finished conversions on a per-channel done vector. The block uses that vector to pace the repeated requests of the held software level.

Top module: `chan_trig_router`

## Requirements
- R1: While reset is asserted and on the first clock after its release, `req_o` is all zeros and the periodic counter restarts from zero.
- R2: A channel whose selector (bits `[4k+3:4k]` of `src_code_i`) is 0 never receives a request.
- R3: Selector 1 gives the channel exactly one request per rising edge of `sw_pulse_i`, however long the strobe is held.
- R4: Selector 2 gives the channel one request on the rising edge of `sw_level_i`, and then one more request after each cycle in which `conv_done_i[k]` is high while the level is still high. When the level is low, no requests are made.
- R5: Selector 4 follows the periodic tick. An 8-bit counter advances on each clock while `sync_en_i` is 1, is held at zero while `sync_en_i` is 0, and wraps to zero after it equals `sync_cmp_i`. The period is therefore `sync_cmp_i`+1 clocks, and the first request appears `sync_cmp_i`+1 clocks after enabling.
- R6: Selectors 5 to 15 map to `evt_i[0]` to `evt_i[10]`. Each is sensitive to the rising edge and gives a single one-cycle request.
- R7: When the scan source selected by `scan_src_i` (same encoding as the channel selectors) fires, every channel with selector 3 and its `scan_mask_i` bit set is requested in the same cycle.
- R8: A channel with selector 3 whose `scan_mask_i` bit is 0 never receives a request.
- R9: A `scan_src_i` value of 3 or 0 never starts a scan.
- R10: With `scan_src_i` = 2 and the level held high, a new scan is issued once every member of the previous scan has reported `conv_done_i`.
- R11: Every request is a one-cycle pulse that appears on the clock edge directly after the source event. Channels that select the same source are requested together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_pulse_i | input | 1 | Global software strobe |
| sw_level_i | input | 1 | Held software level trigger |
| evt_i | input | 11 | External event lines |
| src_code_i | input | 64 | Per-channel 4-bit source selectors, channel k at [4k+3:4k] |
| scan_mask_i | input | 16 | Scan membership mask |
| scan_src_i | input | 4 | Scan source selector |
| sync_en_i | input | 1 | Periodic counter enable |
| sync_cmp_i | input | 8 | Periodic counter compare value |
| conv_done_i | input | 16 | Per-channel conversion-finished strobes from the arbiter |
| req_o | output | 16 | Per-channel request pulses |

## Verification
The hardest case to reach is the repeated scan under the held level. It needs several done strobes to arrive one at a time for the members of the scan, and a new scan may fire only when the last one clears. The bench holds the level high, returns done for one member and checks that no request appears yet, then returns done for the other member and expects the whole scan again on the next edge. The periodic tick is checked by counting edges from the enable, and the reserved scan code is checked by firing every other source while it is selected.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] SRC_NONE  = 4'd0;
  localparam logic [CODE_W-1:0] SRC_PULSE = 4'd1;
  localparam logic [CODE_W-1:0] SRC_LEVEL = 4'd2;
  localparam logic [CODE_W-1:0] SRC_SCAN  = 4'd3;
  localparam logic [CODE_W-1:0] SRC_TICK  = 4'd4;
  localparam logic [CODE_W-1:0] SRC_EVT0  = 4'd5;
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_chk
      // R6
      one_cycle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[b] |=> !rise_o[b]);
    end
  endgenerate
endmodule

// File: rtl/sync_tick.sv
module sync_tick #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = en_i && (cnt_q == cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (fire_o)       cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R5
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_o && cmp_i != '0) |=> (!fire_o || cmp_i == '0));
endmodule

// File: rtl/scan_gen.sv
module scan_gen #(
  parameter int NCH = 16,
  parameter int NSRC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_vec_i,
  input  logic [3:0]        scan_src_i,
  input  logic              level_i,
  input  logic [NCH-1:0]    members_i,
  input  logic [NCH-1:0]    done_i,
  output logic              fire_o
);
  import trig_pkg::*;

  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_left;
  logic           base_fire;
  logic           repeat_fire;

  assign base_fire   = (scan_src_i != SRC_SCAN) && src_vec_i[scan_src_i];
  assign pend_left   = pend_q & ~done_i;
  assign repeat_fire = (scan_src_i == SRC_LEVEL) && level_i &&
                       (|pend_q) && !(|pend_left);
  assign fire_o      = base_fire || repeat_fire;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= '0;
    else if (fire_o) pend_q <= members_i;
    else             pend_q <= pend_left;
  end
endmodule

// File: rtl/chan_req.sv
module chan_req #(
  parameter int NSRC = 16
) (
  input  logic [3:0]      code_i,
  input  logic [NSRC-1:0] src_vec_i,
  input  logic            level_i,
  input  logic            done_i,
  input  logic            scan_fire_i,
  input  logic            member_i,
  output logic            req_o
);
  import trig_pkg::*;

  always_comb begin
    unique case (code_i)
      SRC_NONE:  req_o = 1'b0;
      SRC_SCAN:  req_o = scan_fire_i && member_i;
      SRC_LEVEL: req_o = src_vec_i[SRC_LEVEL] || (level_i && done_i);
      default:   req_o = src_vec_i[code_i];
    endcase
  end
endmodule

// File: rtl/chan_trig_router.sv
module chan_trig_router #(
  parameter int NCH   = 16,
  parameter int NEVT  = 11,
  parameter int CW    = 4,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_pulse_i,
  input  logic              sw_level_i,
  input  logic [NEVT-1:0]   evt_i,
  input  logic [NCH*CW-1:0] src_code_i,
  input  logic [NCH-1:0]    scan_mask_i,
  input  logic [CW-1:0]     scan_src_i,
  input  logic              sync_en_i,
  input  logic [CNT_W-1:0]  sync_cmp_i,
  input  logic [NCH-1:0]    conv_done_i,
  output logic [NCH-1:0]    req_o
);
  import trig_pkg::*;

  localparam int NSRC = 1 << CW;
  localparam int NRAW = NEVT + 2;

  logic [NRAW-1:0] raw_in;
  logic [NRAW-1:0] raw_rise;
  logic            tick;
  logic [NSRC-1:0] src_vec;
  logic [NCH-1:0]  is_scan;
  logic [NCH-1:0]  members;
  logic            scan_fire;
  logic [NCH-1:0]  req_d;

  assign raw_in = {evt_i, sw_level_i, sw_pulse_i};

  rise_detect #(.W(NRAW)) u_rise (
    .clk(clk), .rst_n(rst_n), .sig_i(raw_in), .rise_o(raw_rise)
  );

  sync_tick #(.CNT_W(CNT_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(sync_en_i), .cmp_i(sync_cmp_i), .fire_o(tick)
  );

  genvar s;
  generate
    for (s = 0; s < NSRC; s++) begin : g_src
      if (s == int'(SRC_PULSE)) begin : g_p
        assign src_vec[s] = raw_rise[0];
      end else if (s == int'(SRC_LEVEL)) begin : g_l
        assign src_vec[s] = raw_rise[1];
      end else if (s == int'(SRC_TICK)) begin : g_t
        assign src_vec[s] = tick;
      end else if (s >= int'(SRC_EVT0) && s < int'(SRC_EVT0) + NEVT) begin : g_e
        assign src_vec[s] = raw_rise[s - int'(SRC_EVT0) + 2];
      end else begin : g_z
        assign src_vec[s] = 1'b0;
      end
    end
  endgenerate

  genvar k;
  generate
    for (k = 0; k < NCH; k++) begin : g_ch
      assign is_scan[k] = (src_code_i[k*CW +: CW] == SRC_SCAN);
      chan_req #(.NSRC(NSRC)) u_req (
        .code_i(src_code_i[k*CW +: CW]),
        .src_vec_i(src_vec),
        .level_i(sw_level_i),
        .done_i(conv_done_i[k]),
        .scan_fire_i(scan_fire),
        .member_i(scan_mask_i[k]),
        .req_o(req_d[k])
      );

      // R2
      idle_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_o[k] |-> $past(src_code_i[k*CW +: CW] != SRC_NONE));
      // R8
      non_member_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_scan[k] && !scan_mask_i[k]) |-> !req_o[k]);
      // R9
      reserved_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_scan[k] && scan_src_i == SRC_SCAN) |-> !req_o[k]);
    end
  endgenerate

  assign members = scan_mask_i & is_scan;

  scan_gen #(.NCH(NCH), .NSRC(NSRC)) u_scan (
    .clk(clk), .rst_n(rst_n), .src_vec_i(src_vec), .scan_src_i(scan_src_i),
    .level_i(sw_level_i), .members_i(members), .done_i(conv_done_i),
    .fire_o(scan_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) req_o <= '0;
    else        req_o <= req_d;
  end
endmodule

// File: tb/test_chan_trig_router.sv
`timescale 1ns/1ps
module test_chan_trig_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_pulse_i = 1'b0;
  logic        sw_level_i = 1'b0;
  logic [10:0] evt_i = '0;
  logic [63:0] src_code_i = '0;
  logic [15:0] scan_mask_i = '0;
  logic [3:0]  scan_src_i = '0;
  logic        sync_en_i = 1'b0;
  logic [7:0]  sync_cmp_i = '0;
  logic [15:0] conv_done_i = '0;
  logic [15:0] req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  chan_trig_router i_chan_trig_router (
    .clk(clk), .rst_n(rst_n), .sw_pulse_i(sw_pulse_i), .sw_level_i(sw_level_i),
    .evt_i(evt_i), .src_code_i(src_code_i), .scan_mask_i(scan_mask_i),
    .scan_src_i(scan_src_i), .sync_en_i(sync_en_i), .sync_cmp_i(sync_cmp_i),
    .conv_done_i(conv_done_i), .req_o(req_o)
  );

  // entry: {channel-7 code, stimulated source, expect request, requirement}
  localparam logic [15:0] TBL [12] = '{
    {4'd0,  4'd1,  4'd0, 4'd2},   // R2
    {4'd1,  4'd1,  4'd1, 4'd3},   // R3
    {4'd1,  4'd2,  4'd0, 4'd3},   // R3
    {4'd2,  4'd2,  4'd1, 4'd4},   // R4
    {4'd2,  4'd1,  4'd0, 4'd4},   // R4
    {4'd5,  4'd5,  4'd1, 4'd6},   // R6
    {4'd5,  4'd6,  4'd0, 4'd6},   // R6
    {4'd15, 4'd15, 4'd1, 4'd6},   // R6
    {4'd10, 4'd10, 4'd1, 4'd6},   // R6
    {4'd3,  4'd1,  4'd0, 4'd8},   // R8
    {4'd0,  4'd5,  4'd0, 4'd2},   // R2
    {4'd12, 4'd11, 4'd0, 4'd11}   // R11
  };

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string rq);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: req_o=%h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic drive_src(input int s, input logic v);
    if (s == 1) sw_pulse_i = v;
    else if (s == 2) sw_level_i = v;
    else if (s >= 5) evt_i[s-5] = v;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(req_o, 16'h0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(req_o, 16'h0, "R1");

    // table walk: one pulse on a source, channel 7 selects a code
    for (int i = 0; i < 12; i++) begin
      src_code_i = '0;
      src_code_i[7*4 +: 4] = TBL[i][15:12];
      drive_src(int'(TBL[i][11:8]), 1'b1);
      @(negedge clk);
      check(req_o, TBL[i][4] ? 16'h0080 : 16'h0, $sformatf("R%0d", TBL[i][3:0]));
      drive_src(int'(TBL[i][11:8]), 1'b0);
      @(negedge clk);
      check(req_o, 16'h0, "R11 pulse width");
      @(negedge clk);
    end

    // R3 held strobe gives only one request
    src_code_i = '0; src_code_i[0 +: 4] = 4'd1;
    sw_pulse_i = 1'b1;
    @(negedge clk); check(req_o, 16'h0001, "R3");
    @(negedge clk); check(req_o, 16'h0000, "R3 held");
    sw_pulse_i = 1'b0; @(negedge clk);

    // R6 held event, two channels on same source (R11)
    src_code_i = '0; src_code_i[3*4 +: 4] = 4'd7; src_code_i[11*4 +: 4] = 4'd7;
    evt_i[2] = 1'b1;
    @(negedge clk); check(req_o, 16'h0808, "R6 R11 shared source");
    @(negedge clk); check(req_o, 16'h0000, "R6 held");
    evt_i = '0; @(negedge clk);

    // R4 level repeat paced by done
    src_code_i = '0; src_code_i[2*4 +: 4] = 4'd2;
    sw_level_i = 1'b1;
    @(negedge clk); check(req_o, 16'h0004, "R4 rise");
    @(negedge clk); check(req_o, 16'h0000, "R4 wait");
    conv_done_i[2] = 1'b1;
    @(negedge clk); check(req_o, 16'h0004, "R4 repeat");
    conv_done_i[2] = 1'b0;
    @(negedge clk); check(req_o, 16'h0000, "R4 idle");
    sw_level_i = 1'b0; conv_done_i[2] = 1'b1;
    @(negedge clk); check(req_o, 16'h0000, "R4 level low");
    conv_done_i = '0; @(negedge clk);

    // R5 periodic tick, compare 3 -> period 4
    src_code_i = '0; src_code_i[4*4 +: 4] = 4'd4;
    sync_cmp_i = 8'd3; sync_en_i = 1'b1;
    for (int c = 1; c <= 12; c++) begin
      @(negedge clk);
      check(req_o, (c % 4 == 0) ? 16'h0010 : 16'h0, "R5");
    end
    sync_en_i = 1'b0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check(req_o, 16'h0, "R5 disabled");
    end

    // R7 scan on event 0, members ch1 ch9, ch3 not in mask, ch5 single on event 0
    src_code_i = '0;
    src_code_i[1*4 +: 4] = 4'd3; src_code_i[3*4 +: 4] = 4'd3;
    src_code_i[9*4 +: 4] = 4'd3; src_code_i[5*4 +: 4] = 4'd5;
    scan_mask_i = 16'h0602; scan_src_i = 4'd5;
    @(negedge clk);
    evt_i[0] = 1'b1;
    @(negedge clk); check(req_o, 16'h0222, "R7 R8");
    evt_i[0] = 1'b0;
    @(negedge clk); check(req_o, 16'h0, "R7 end");

    // R9 reserved and null scan selectors
    scan_src_i = 4'd3;
    sw_pulse_i = 1'b1; sw_level_i = 1'b1; evt_i = '1;
    @(negedge clk); check(req_o, 16'h0020, "R9 reserved");
    sw_pulse_i = 1'b0; sw_level_i = 1'b0; evt_i = '0;
    @(negedge clk);
    scan_src_i = 4'd0; sw_pulse_i = 1'b1;
    @(negedge clk); check(req_o, 16'h0, "R9 none");
    sw_pulse_i = 1'b0; @(negedge clk);

    // R10 level-driven scan repeats after all members done
    scan_src_i = 4'd2;
    sw_level_i = 1'b1;
    @(negedge clk); check(req_o, 16'h0202, "R10 first scan");
    conv_done_i[1] = 1'b1;
    @(negedge clk); check(req_o, 16'h0, "R10 partial");
    conv_done_i = '0; conv_done_i[9] = 1'b1;
    @(negedge clk); check(req_o, 16'h0202, "R10 rescan");
    conv_done_i = '0;
    @(negedge clk); check(req_o, 16'h0, "R10 gap");
    sw_level_i = 1'b0; conv_done_i = 16'h0202;
    @(negedge clk); check(req_o, 16'h0, "R10 level low");
    conv_done_i = '0;

    // R1 reset mid-run clears counter
    src_code_i = '0; src_code_i[0 +: 4] = 4'd4;
    sync_cmp_i = 8'd2; sync_en_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); check(req_o, 16'h0, "R1 reset");
    rst_n = 1'b1;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      check(req_o, (c == 3) ? 16'h0001 : 16'h0, "R1 R5 restart");
    end

    finish_run();
  end
endmodule